// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a system clock into CAN bit timing. A prescaler divides the clock into time quanta (TQ), and each nominal bit is split into four parts: a one-quantum sync part, a propagation part and two phase buffers. The block gives the protocol logic a one-cycle strobe where the received level is to be sampled and another where the next bit may be driven.

Falling edges on the received level (recessive 1 to dominant 0) keep the bit clock aligned with the bus. With the hard-sync enable set, such an edge restarts the bit. Otherwise the edge moves the bit boundary by at most the jump width, and only once per bit. A configuration that breaks the timing rules raises an error flag and freezes the counters.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_tick` is a one-cycle pulse that repeats every brp_cfg+1 clock cycles while the configuration is legal.
- R2: With no received edges, consecutive `tx_pt` strobes are (brp_cfg+1)*(4+prop_cfg+ph1_cfg+ph2_cfg) clock cycles apart. The sync part is 1 TQ, the propagation part prop_cfg+1 TQ and the phase buffers ph1_cfg+1 and ph2_cfg+1 TQ.
- R3: `tx_pt` fires on the last clock of the second phase buffer, which is when the next sync part starts. `sample_pt` fires on the last clock of the first phase buffer, (brp_cfg+1)*(3+prop_cfg+ph1_cfg) cycles after `tx_pt`. Neither strobe is active during reset.
- R4: `cfg_err` is 1 exactly when one of these holds: the second phase buffer is under 2 TQ (ph2_cfg=0), the second phase buffer is longer than the first, the jump width (sjw_cfg+1 TQ) exceeds the first phase buffer, or the total bit falls outside 8 to 25 TQ.
- R5: While `cfg_err` is 1, no `tq_tick`, `sample_pt` or `tx_pt` is produced.
- R6: With `hsync_en`=1, a falling edge of `rx_level` makes the next clock start a new bit at the first cycle of its sync part.
- R7: With `hsync_en`=0, the first falling edge in the propagation part or the first phase buffer lengthens the first phase buffer by min(e, sjw_cfg+1) TQ. Here e counts the TQs from the end of the sync part up to and including the TQ that holds the edge.
- R8: With `hsync_en`=0, the first falling edge in the second phase buffer shortens that buffer by min(r, sjw_cfg+1) TQ. Here r is the number of TQs left in the buffer, counting the one that holds the edge.
- R9: A falling edge in the sync part changes nothing. Only the first edge after the sync part of a bit adjusts that bit.
- R10: Rising edges of `rx_level` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| brp_cfg | input | 6 | Prescaler value; TQ = brp_cfg+1 clocks |
| prop_cfg | input | 3 | Propagation part length minus 1, in TQ |
| ph1_cfg | input | 3 | First phase buffer length minus 1, in TQ |
| ph2_cfg | input | 3 | Second phase buffer length minus 1, in TQ |
| sjw_cfg | input | 2 | Jump width minus 1, in TQ |
| hsync_en | input | 1 | Falling edges restart the bit |
| rx_level | input | 1 | Received bus level, 1 = recessive |
| tq_tick | output | 1 | Last clock of each TQ |
| sample_pt | output | 1 | Sample strobe |
| tx_pt | output | 1 | Transmit strobe, start of bit |
| cfg_err | output | 1 | Configuration violates a timing rule |

## Verification
The bench uses the default widths: a 6-bit prescaler, 3-bit segment fields and a 2-bit jump width. With these it can run both the shortest 8-TQ bit and the longest 25-TQ bit, as well as the largest prescaler value of 63. The resynchronization cases use a prescaler of 0, so each TQ is one clock. The bench can then drive an edge into a chosen quantum and predict the shifted strobes to the exact cycle. The jump width is set once to 2 TQ, so that the limit caps the adjustment, and once to 4 TQ, so that the phase error itself sets the amount.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W  = 6,
  parameter int PRS_W  = 3,
  parameter int PH_W   = 3,
  parameter int SJW_W  = 2,
  parameter int MIN_TQ = 8,
  parameter int MAX_TQ = 25,
  parameter int IPT_TQ = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp_cfg,
  input  logic [PRS_W-1:0] prop_cfg,
  input  logic [PH_W-1:0]  ph1_cfg,
  input  logic [PH_W-1:0]  ph2_cfg,
  input  logic [SJW_W-1:0] sjw_cfg,
  input  logic             hsync_en,
  input  logic             rx_level,
  output logic             tq_tick,
  output logic             sample_pt,
  output logic             tx_pt,
  output logic             cfg_err
);
  localparam int FW = (PRS_W > PH_W) ? PRS_W : PH_W;
  localparam int LW = FW + 3;

  typedef enum logic [1:0] {S_SYNC, S_PROP, S_PH1, S_PH2} seg_t;

  logic [BRP_W-1:0] pre_q;
  seg_t             seg_q;
  logic [LW-1:0]    cnt_q, ext_q, shr_q;
  logic             adj_q, rx_q;

  wire [LW-1:0] prop_len = LW'(prop_cfg) + LW'(1);
  wire [LW-1:0] ph1_base = LW'(ph1_cfg) + LW'(1);
  wire [LW-1:0] ph2_base = LW'(ph2_cfg) + LW'(1);
  wire [LW-1:0] sjw_len  = LW'(sjw_cfg) + LW'(1);
  wire [LW-1:0] total    = LW'(1) + prop_len + ph1_base + ph2_base;

  assign cfg_err = (ph2_base < LW'(IPT_TQ)) || (ph2_base > ph1_base) ||
                   (sjw_len > ph1_base) || (total < LW'(MIN_TQ)) || (total > LW'(MAX_TQ));

  assign tq_tick = !cfg_err && (pre_q >= brp_cfg);

  wire fall     = rx_q && !rx_level;
  wire hard     = fall && hsync_en && !cfg_err;
  wire resync   = fall && !hsync_en && !adj_q && !cfg_err;
  wire late     = resync && (seg_q == S_PROP || seg_q == S_PH1);
  wire early    = resync && (seg_q == S_PH2);

  wire [LW-1:0] late_e  = (seg_q == S_PROP) ? cnt_q + LW'(1) : prop_len + cnt_q + LW'(1);
  wire [LW-1:0] early_e = ph2_base - cnt_q;
  wire [LW-1:0] ext_now = late  ? ((late_e  < sjw_len) ? late_e  : sjw_len) : ext_q;
  wire [LW-1:0] shr_now = early ? ((early_e < sjw_len) ? early_e : sjw_len) : shr_q;

  logic [LW-1:0] cur_len;
  always_comb begin
    case (seg_q)
      S_SYNC:  cur_len = LW'(1);
      S_PROP:  cur_len = prop_len;
      S_PH1:   cur_len = ph1_base + ext_now;
      default: cur_len = ph2_base - shr_now;
    endcase
  end

  wire seg_end = (cnt_q + LW'(1)) >= cur_len;

  assign sample_pt = tq_tick && seg_q == S_PH1 && seg_end;
  assign tx_pt     = tq_tick && seg_q == S_PH2 && seg_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      seg_q <= S_SYNC;
      cnt_q <= '0;
      ext_q <= '0;
      shr_q <= '0;
      adj_q <= 1'b0;
      rx_q  <= 1'b1;
    end else begin
      rx_q <= rx_level;
      if (cfg_err || hard) begin
        pre_q <= '0;
        seg_q <= S_SYNC;
        cnt_q <= '0;
        ext_q <= '0;
        shr_q <= '0;
        adj_q <= 1'b0;
      end else begin
        if (late)  begin ext_q <= ext_now; adj_q <= 1'b1; end
        if (early) begin shr_q <= shr_now; adj_q <= 1'b1; end
        pre_q <= tq_tick ? '0 : pre_q + BRP_W'(1);
        if (tq_tick) begin
          if (seg_end) begin
            cnt_q <= '0;
            seg_q <= seg_t'(seg_q + 2'd1);
            if (seg_q == S_PH2) begin
              ext_q <= '0;
              shr_q <= '0;
              adj_q <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q + LW'(1);
          end
        end
      end
    end
  end

  a_r3_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_pt && tx_pt));
  a_r5_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!tq_tick && !sample_pt && !tx_pt));
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && brp_cfg != '0) |=> (!tq_tick || $changed(brp_cfg)));
  a_r3_bit_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pt |=> (seg_q == S_SYNC && cnt_q == '0));
  a_r6_hard_sync: assert property (@(posedge clk) disable iff (!rst_n)
    hard |=> (seg_q == S_SYNC && cnt_q == '0 && pre_q == '0));
  a_r9_one_adjust: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_q && seg_q != S_PH2) |=> $stable(ext_q) || seg_q == S_SYNC);
endmodule

// File: tb/can_bit_timer_test.sv
`timescale 1ns/1ps
module can_bit_timer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] brp = '0;
  logic [2:0] prs = 3'd1, ph1 = 3'd3, ph2 = 3'd3;
  logic [1:0] sjw = 2'd1;
  logic hs = 1'b0, rx = 1'b1;
  logic tq_tick, sample_pt, tx_pt, cfg_err;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  can_bit_timer uut (.clk(clk), .rst_n(rst_n), .brp_cfg(brp), .prop_cfg(prs),
    .ph1_cfg(ph1), .ph2_cfg(ph2), .sjw_cfg(sjw), .hsync_en(hs), .rx_level(rx),
    .tq_tick(tq_tick), .sample_pt(sample_pt), .tx_pt(tx_pt), .cfg_err(cfg_err));

  // brp, prop, ph1, ph2, sjw, err, period, sample offset
  localparam int TBL [9][8] = '{
    '{0, 1, 3, 3, 1, 0, 11, 7},
    '{2, 0, 2, 2, 0, 0, 24, 15},
    '{1, 7, 7, 7, 3, 0, 50, 34},
    '{3, 3, 1, 1, 1, 0, 36, 28},
    '{63, 0, 2, 2, 0, 0, 512, 320},
    '{0, 0, 2, 1, 0, 1, 0, 0},
    '{0, 3, 3, 0, 0, 1, 0, 0},
    '{0, 3, 2, 3, 0, 1, 0, 0},
    '{0, 3, 1, 1, 2, 1, 0, 0}};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bitrun(input int d1, input int r1, input int d2,
                        output int sofs, output int per);
    bit got = 0;
    sofs = -1; per = -1;
    for (int k = 0; k < 3000 && !got; k++) begin
      @(negedge clk);
      if (tx_pt) got = 1;
    end
    if (!got) return;
    for (int k = 1; k < 4000; k++) begin
      @(negedge clk);
      if (sample_pt && sofs < 0) sofs = k;
      if (tx_pt) begin per = k; break; end
      if (k == d1) rx = 1'b0;
      if (k == r1) rx = 1'b1;
      if (k == d2) rx = 1'b0;
    end
    rx = 1'b1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s, p, cnt;
    @(negedge clk);
    check("R3 reset tx_pt", int'(tx_pt), 0);
    check("R3 reset sample_pt", int'(sample_pt), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      brp = 6'(TBL[i][0]); prs = 3'(TBL[i][1]); ph1 = 3'(TBL[i][2]);
      ph2 = 3'(TBL[i][3]); sjw = 2'(TBL[i][4]);
      do_reset();
      check($sformatf("R4 cfg_err vec%0d", i), int'(cfg_err), TBL[i][5]);
      if (TBL[i][5] == 0) begin
        bitrun(-1, -1, -1, s, p);
        check($sformatf("R2 period vec%0d", i), p, TBL[i][6]);
        check($sformatf("R3 sample offset vec%0d", i), s, TBL[i][7]);
        while (!tq_tick) @(negedge clk);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!tq_tick && cnt < 100);
        check($sformatf("R1 tick gap vec%0d", i), cnt, TBL[i][0] + 1);
      end else begin
        cnt = 0;
        for (int k = 0; k < 300; k++) begin
          @(negedge clk);
          if (tq_tick || tx_pt || sample_pt) cnt++;
        end
        check($sformatf("R5 no strobes vec%0d", i), cnt, 0);
      end
    end

    brp = 6'd0; prs = 3'd1; ph1 = 3'd3; ph2 = 3'd3; sjw = 2'd1;
    do_reset();
    bitrun(4, -1, -1, s, p);
    check("R7 late capped sample", s, 9);
    check("R7 late capped period", p, 13);
    bitrun(-1, -1, -1, s, p);
    check("R7 next bit normal", p, 11);
    bitrun(8, -1, -1, s, p);
    check("R8 early sample", s, 7);
    check("R8 early capped period", p, 9);
    bitrun(1, 5, -1, s, p);
    check("R9 sync edge sample", s, 7);
    check("R10 rising ignored period", p, 11);
    sjw = 2'd3;
    bitrun(4, 5, 6, s, p);
    check("R7 late uncapped sample", s, 10);
    check("R9 one adjust period", p, 14);
    sjw = 2'd1;
    hs = 1'b1;
    bitrun(5, -1, -1, s, p);
    check("R6 hard sync sample", s, 12);
    check("R6 hard sync period", p, 16);
    hs = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule